// File: doc/BRIEF.md
# Right-Justified Two-Channel Serial Audio Receiver

This block accepts a two-channel serial audio stream made of three wires: a bit clock, a word-select clock and a data line. Each half of a frame carries one 16-bit two's-complement sample, sent most significant bit first. The sample is packed against the far end of its half-frame, so its least significant bit is the last bit before word-select changes level. Any bit clocks in a half-frame ahead of those 16 bits hold no meaning. The block keeps the most recent 16 bits it has seen. Each time word-select changes level, it hands those bits over as the finished sample of the channel that has just ended.

All three serial inputs are sampled by the system clock through two-flop synchronisers. The bit-clock and word-select edges are then found inside the system-clock domain. This means the serial clocks can have any phase relative to the system clock, provided each bit-clock phase lasts long enough to be seen. A finished sample goes into a left or a right output register, together with a one-cycle valid strobe for that channel. After reset the block stays silent until it has collected a full word.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, both sample outputs read zero and neither valid strobe is raised until a complete word has been received.
- R2: A word is assembled most significant bit first from the data level sampled at each rising bit-clock edge. It is presented as a 16-bit two's-complement value in which the last bit received is bit 0.
- R3: The word that was sent while word-select was high goes to the left output. The word that was sent while word-select was low goes to the right output.
- R4: The captured word is formed from the last 16 bits before the word-select transition. Any earlier bits in the same half-frame have no effect on the captured value.
- R5: Frames of 32, 48 and 64 bit clocks, meaning 16, 24 and 32 bits per half-frame, all deliver correct samples.
- R6: Each completed word raises the valid strobe of its channel for exactly one system-clock cycle. The left and right strobes are never high in the same cycle.
- R7: If fewer than 16 bits have been received since reset, the word-select transition that ends them produces no strobe and no register update.
- R8: A sample output changes only in the cycle in which its own valid strobe is high, and otherwise holds its value.
- R9: Operation does not depend on the phase of the serial clocks relative to the system clock, provided each bit-clock high and low phase lasts at least three system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| wsel_i | input | 1 | Word select: high for the left word, low for the right word |
| sdata_i | input | 1 | Serial data, MSB first, right-justified |
| left_o | output | WORD_W | Last completed left sample |
| right_o | output | WORD_W | Last completed right sample |
| left_vld_o | output | 1 | One-cycle strobe when left_o is updated |
| right_vld_o | output | 1 | One-cycle strobe when right_o is updated |

## Verification
The bench builds the receiver with its default parameters: a word width of 16 and two synchroniser stages. With these values the bench can drive real frame lengths of 32, 48 and 64 bit clocks, including leading junk bits that the receiver must drop. It also drives bit-clock half periods that are not whole multiples of the 8 ns system clock, so the point at which the synchronisers resolve each edge shifts from bit to bit. A reset followed by a short first half-frame tests the rule that no strobe is raised until a full word has arrived.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wsel_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              left_vld_o,
  output logic              right_vld_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] bclk_s, ws_s, sd_s;
  logic                   bclk_d;
  logic                   ws_prev, ws_known;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       nbits;

  wire bit_tick  = bclk_s[TOP] & ~bclk_d;
  wire ws_now    = ws_s[TOP];
  wire word_end  = bit_tick & ws_known & (ws_now != ws_prev);
  wire word_full = (nbits == CNT_W'(WORD_W));
  wire take      = word_end & word_full;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          bclk_s <= '0;
          ws_s   <= '0;
          sd_s   <= '0;
        end else begin
          bclk_s <= bclk_i;
          ws_s   <= wsel_i;
          sd_s   <= sdata_i;
        end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          bclk_s <= '0;
          ws_s   <= '0;
          sd_s   <= '0;
        end else begin
          bclk_s <= {bclk_s[TOP-1:0], bclk_i};
          ws_s   <= {ws_s[TOP-1:0], wsel_i};
          sd_s   <= {sd_s[TOP-1:0], sdata_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s[TOP];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ws_prev  <= 1'b0;
      ws_known <= 1'b0;
      shreg    <= '0;
      nbits    <= '0;
    end else if (bit_tick) begin
      ws_prev  <= ws_now;
      ws_known <= 1'b1;
      shreg    <= {shreg[WORD_W-2:0], sd_s[TOP]};
      if (word_end)        nbits <= CNT_W'(1);
      else if (!word_full) nbits <= nbits + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      left_vld_o  <= take & ws_prev;
      right_vld_o <= take & ~ws_prev;
      if (take & ws_prev)  left_o  <= shreg;
      if (take & ~ws_prev) right_o <= shreg;
    end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         left_vld_o,
  input logic         right_vld_o
);

  p_left_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld_o |=> !left_vld_o);

  p_right_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    right_vld_o |=> !right_vld_o);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_vld_o && right_vld_o));

  p_left_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_o != $past(left_o)) |-> left_vld_o);

  p_right_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (right_o != $past(right_o)) |-> right_vld_o);

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .left_o(left_o), .right_o(right_o),
  .left_vld_o(left_vld_o), .right_vld_o(right_vld_o)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, wsel = 1'b1, sdata = 1'b0;
  logic [15:0] left_o, right_o;
  logic left_vld_o, right_vld_o;

  int n_chk = 0, n_bad = 0;
  int n_l = 0, n_r = 0;
  logic [15:0] got_l = '0, got_r = '0;
  int half_ns = 32;

  always #4 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wsel_i(wsel), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o),
    .left_vld_o(left_vld_o), .right_vld_o(right_vld_o)
  );

  always @(negedge clk) begin
    if (left_vld_o)  begin n_l++; got_l = left_o;  end
    if (right_vld_o) begin n_r++; got_r = right_o; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic ws, logic d);
    wsel = ws; sdata = d;
    #(half_ns) bclk = 1'b1;
    #(half_ns) bclk = 1'b0;
  endtask

  task automatic send_half(logic ws, logic [15:0] w, int nbits, logic [31:0] junk);
    for (int i = 0; i < nbits - 16; i++) send_bit(ws, junk[i % 32]);
    for (int i = 15; i >= 0; i--) send_bit(ws, w[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; wsel = 1'b1; sdata = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  // one stereo frame followed by a single opening bit of the next left word
  task automatic frame(string tag, logic [15:0] l, logic [15:0] r, int nbits, logic [31:0] junk);
    int l0 = n_l, r0 = n_r;
    send_half(1'b1, l, nbits, junk);
    send_half(1'b0, r, nbits, ~junk);
    send_bit(1'b1, junk[0]);
    repeat (8) @(posedge clk);
    #2;
    check({tag, " R2 R3 left value"}, 32'(got_l), 32'(l));
    check({tag, " R2 R3 right value"}, 32'(got_r), 32'(r));
    check({tag, " R6 one left strobe"}, 32'(n_l - l0), 32'd1);
    check({tag, " R6 one right strobe"}, 32'(n_r - r0), 32'd1);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 left zero", 32'(left_o), 32'd0);
    check("R1 right zero", 32'(right_o), 32'd0);
    check("R1 no strobes", 32'(n_l + n_r), 32'd0);
  endtask

  task automatic t_partial_first();
    // R7: 10 left bits only, then a full right word
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1);
    send_half(1'b0, 16'hC3A5, 16, 32'h0);
    send_bit(1'b1, 1'b0);
    repeat (8) @(posedge clk);
    #2;
    check("R7 no left strobe", 32'(n_l), 32'd0);
    check("R7 R8 left holds zero", 32'(left_o), 32'd0);
    check("R7 right captured", 32'(got_r), 32'hC3A5);
  endtask

  task automatic t_junk_ignored();
    // R4: leading bits all ones or all zeros must not leak into the word
    half_ns = 27;
    frame("R4 R5 64fs ones", 16'h0001, 16'h8000, 32, 32'hFFFF_FFFF);
    frame("R4 R5 64fs zeros", 16'hFFFE, 16'h7FFF, 32, 32'h0000_0000);
  endtask

  task automatic t_rates();
    half_ns = 32;
    frame("R5 32fs", 16'h1234, 16'hFEDC, 16, 32'h0);
    frame("R5 32fs neg", 16'h8000, 16'h7FFF, 16, 32'h0);
    half_ns = 51;
    frame("R5 R9 48fs", 16'hA5A5, 16'h5A5A, 24, 32'h00FF_00FF);
  endtask

  task automatic t_phase();
    half_ns = 25;
    #3;
    frame("R9 offset a", 16'hFFFF, 16'h0000, 20, 32'hAAAA_5555);
    #5;
    half_ns = 29;
    frame("R9 offset b", 16'h6B2D, 16'h94D2, 32, 32'h1357_9BDF);
  endtask

  task automatic t_hold();
    // R8: a long idle gap leaves both outputs untouched
    logic [15:0] l = left_o, r = right_o;
    repeat (200) @(posedge clk);
    #2;
    check("R8 left holds", 32'(left_o), 32'(l));
    check("R8 right holds", 32'(right_o), 32'(r));
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_partial_first();
    t_rates();
    t_junk_ignored();
    t_phase();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule